// File: doc/BRIEF.md
# Lockdown-Aware Cache Victim Selector

This block decides which way of a four-way set-associative cache receives a newly allocated line. A software-writable mask holds one lock bit per way. A way whose bit is set never receives a new line. Lookups are not affected: lines already resident in a locked way still hit, because hit detection lies outside this block. The ways that are not locked share allocations through a round-robin pointer. The pointer skips locked ways and, after each allocation, moves to the way just past the one chosen.

Allocation requests get their answer combinationally, in the cycle they are raised. The answer is a binary way index with a valid flag. When every way is locked, the answer is a no-allocate indication instead.

Software can steer all fills into a single way by clearing that way's bit and setting the other three. The mask is written and read back through a plain register-access port. Only the low four bits are stored, and the upper bits read back as zero.

Top module: `lockvict_top`

## Requirements
- R1: A register write stores `reg_wdata[3:0]` as the lock mask, with bit i locking way i. The upper write bits are discarded. `reg_rdata` always returns the mask in bits [3:0] and zero in bits [31:4].
- R2: Synchronous active-low reset clears the mask to 0 and the pointer to way 0. The first request after reset is therefore given way 0.
- R3: While `victim_valid` is 1, the lock bit of `victim_way` is 0. A locked way is never selected.
- R4: The chosen way is the first unlocked way found by searching upward from the pointer and wrapping past way 3 to way 0. After an allocation, the pointer becomes (chosen way + 1) mod 4. Over time, every unlocked way is chosen.
- R5: When exactly one lock bit is 0, every request is given that way.
- R6: When all four lock bits are 1, a request raises `no_alloc`, keeps `victim_valid` low and leaves the pointer unchanged.
- R7: The response appears in the same cycle as `alloc_req`. With no request, both `victim_valid` and `no_alloc` are 0 and the pointer holds its value.
- R8: A mask write takes effect from the next cycle on. A request raised in the same cycle as a write is served with the old mask.
- R9: `victim_way` is a 2-bit binary way index (0 to 3). It is meaningful only while `victim_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Lock-mask register write strobe |
| reg_wdata | input | 32 | Write data; only bits [3:0] are kept |
| reg_rdata | output | 32 | Lock mask readback, upper bits zero |
| alloc_req | input | 1 | Allocation request for this cycle |
| victim_valid | output | 1 | A way was chosen for this request |
| victim_way | output | 2 | Binary index of the chosen way |
| no_alloc | output | 1 | Request refused: all ways locked |

## Verification
The assertions take for granted that `alloc_req` and `reg_wr` are clean 0/1 levels that change only between clock edges. They also assume that a request and a write in the same cycle are meant to be ordered as old mask first, then new mask. The bench drives every input just after the falling edge and reads the combinational response before the next rising edge, so each request is observed against the mask and pointer of that cycle. The random phase mixes mask writes with requests on the same cycle and includes the all-locked and single-unlocked masks. This keeps the ordering rule and every branch of the search within what the properties cover.

// File: rtl/lockvict_pkg.sv
// Package: shared defaults for the lockdown-aware victim selector.
// Assumes the way count is a power of two so index arithmetic wraps naturally.
package lockvict_pkg;
    localparam int unsigned DEF_WAYS  = 4;
    localparam int unsigned DEF_REG_W = 32;

    // Decision returned to the allocation logic
    typedef enum logic [1:0] {
        DEC_IDLE    = 2'd0,
        DEC_ALLOC   = 2'd1,
        DEC_REFUSED = 2'd2
    } alloc_dec_e;
endpackage

// File: rtl/lockvict_mask_reg.sv
// Module: lock mask register.
// Holds one lock bit per way, written from the low bits of a wide data word.
// Readback is zero-extended. Assumes the write strobe is a clean level.
module lockvict_mask_reg #(
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned REG_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [REG_W-1:0]    wdata,
    output logic [NUM_WAYS-1:0] lock_q,
    output logic [REG_W-1:0]    rdata
);
    logic unused_hi;
    assign unused_hi = ^wdata[REG_W-1:NUM_WAYS];

    // Capture the low bits on a write; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  lock_q <= '0;
        else if (wr) lock_q <= wdata[NUM_WAYS-1:0];
    end

    // Zero-extended readback of the stored mask
    always_comb rdata = REG_W'(lock_q);

    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> lock_q == $past(wdata[NUM_WAYS-1:0]));
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(lock_q));
endmodule

// File: rtl/lockvict_pick.sv
// Module: circular first-free search.
// Starting at the pointer, finds the first way whose lock bit is clear,
// wrapping past the top way. Purely combinational.
module lockvict_pick #(
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] lock,
    input  logic [IDX_W-1:0]    start,
    output logic                found,
    output logic [IDX_W-1:0]    way
);
    logic [IDX_W-1:0]    cand [NUM_WAYS];
    logic [NUM_WAYS-1:0] cand_free;

    // One candidate per search offset
    for (genvar k = 0; k < NUM_WAYS; k++) begin : g_cand
        assign cand[k]      = start + IDX_W'(k);
        assign cand_free[k] = ~lock[cand[k]];
    end

    // Lowest offset with a free way wins
    always_comb begin
        found = |cand_free;
        way   = start;
        for (int k = NUM_WAYS - 1; k >= 0; k--) begin
            if (cand_free[k]) way = cand[k];
        end
    end
endmodule

// File: rtl/lockvict_ptr.sv
// Module: round-robin replacement pointer.
// Moves to the way after the chosen one on each allocation; holds otherwise.
module lockvict_ptr #(
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [IDX_W-1:0] chosen,
    output logic [IDX_W-1:0] ptr_q
);
    // Step past the chosen way after an allocation
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (advance) ptr_q <= chosen + IDX_W'(1);
    end

    p_ptr_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> ptr_q == $past(chosen) + IDX_W'(1));
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q));
endmodule

// File: rtl/lockvict_top.sv
// Module: lockdown-aware victim selector (top).
// Answers each allocation request in the same cycle with a way index that
// is never locked, or with a refusal when all ways are locked.
// Assumes requests and writes are clean levels sampled at the rising edge.
module lockvict_top
    import lockvict_pkg::*;
#(
    parameter int unsigned NUM_WAYS = DEF_WAYS,
    parameter int unsigned REG_W    = DEF_REG_W,
    localparam int unsigned IDX_W   = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             alloc_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_way,
    output logic             no_alloc
);
    logic [NUM_WAYS-1:0] lock_q;
    logic [IDX_W-1:0]    ptr_q;
    logic                any_free;
    logic [IDX_W-1:0]    pick_way;
    alloc_dec_e          dec;

    lockvict_mask_reg #(.NUM_WAYS(NUM_WAYS), .REG_W(REG_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .lock_q(lock_q), .rdata(reg_rdata)
    );

    lockvict_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .lock(lock_q), .start(ptr_q), .found(any_free), .way(pick_way)
    );

    lockvict_ptr #(.NUM_WAYS(NUM_WAYS)) u_ptr (
        .clk(clk), .rst_n(rst_n), .advance(victim_valid),
        .chosen(pick_way), .ptr_q(ptr_q)
    );

    // Classify this cycle's request
    always_comb begin
        if (!alloc_req)    dec = DEC_IDLE;
        else if (any_free) dec = DEC_ALLOC;
        else               dec = DEC_REFUSED;
    end

    // Drive the response outputs from the decision
    always_comb begin
        victim_valid = (dec == DEC_ALLOC);
        no_alloc     = (dec == DEC_REFUSED);
        victim_way   = pick_way;
    end

    p_never_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> !lock_q[victim_way]);
    p_all_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && (&lock_q)) |-> (no_alloc && !victim_valid));
    p_single_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && $countones(~lock_q) == 1) |-> (victim_valid && !lock_q[victim_way]));
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_req |-> (!victim_valid && !no_alloc));
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({victim_valid, no_alloc}));
    p_start_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !lock_q[ptr_q]) |-> (victim_valid && victim_way == ptr_q));
endmodule

// File: tb/tb_lockvict_top.sv
module tb_lockvict_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        alloc_req = 1'b0;
    logic        victim_valid;
    logic [1:0]  victim_way;
    logic        no_alloc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    lockvict_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alloc_req(alloc_req),
        .victim_valid(victim_valid), .victim_way(victim_way), .no_alloc(no_alloc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Vector: wr, wdata, req, exp_valid, exp_way, exp_noalloc, exp_rdata[3:0]
    localparam int NV = 17;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd0, 1'b0, 4'h0},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd1, 1'b0, 4'h0},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd2, 1'b0, 4'h0},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd3, 1'b0, 4'h0},
        {1'b1, 32'h0000_0005, 1'b1, 1'b1, 2'd0, 1'b0, 4'h0},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd1, 1'b0, 4'h5},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd3, 1'b0, 4'h5},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd1, 1'b0, 4'h5},
        {1'b1, 32'hFFFF_FFF7, 1'b0, 1'b0, 2'd0, 1'b0, 4'h5},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd3, 1'b0, 4'h7},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd3, 1'b0, 4'h7},
        {1'b1, 32'h0000_000F, 1'b0, 1'b0, 2'd0, 1'b0, 4'h7},
        {1'b0, 32'h0,        1'b1, 1'b0, 2'd0, 1'b1, 4'hF},
        {1'b1, 32'h0000_0009, 1'b0, 1'b0, 2'd0, 1'b0, 4'hF},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd1, 1'b0, 4'h9},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd2, 1'b0, 4'h9},
        {1'b0, 32'h0,        1'b1, 1'b1, 2'd1, 1'b0, 4'h9}
    };

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] m_mask;
        logic [1:0] m_ptr;
        logic       e_v;
        logic [1:0] e_w;
        int         seen [4];
        repeat (3) @(negedge clk);
        #1;
        // R2: reset state
        chk("R2 reset rdata", reg_rdata, 32'h0);
        chk("R7 idle valid in reset", {31'b0, victim_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_wr    = VEC[i][41];
            reg_wdata = VEC[i][40:9];
            alloc_req = VEC[i][8];
            #1;
            chk($sformatf("R3/R4/R9 step %0d valid", i), {31'b0, victim_valid}, {31'b0, VEC[i][7]});
            if (VEC[i][7])
                chk($sformatf("R4/R5/R8 step %0d way", i), {30'b0, victim_way}, {30'b0, VEC[i][6:5]});
            chk($sformatf("R6/R7 step %0d no_alloc", i), {31'b0, no_alloc}, {31'b0, VEC[i][4]});
            chk($sformatf("R1 step %0d rdata", i), reg_rdata, {28'b0, VEC[i][3:0]});
        end
        @(negedge clk);
        reg_wr = 1'b0; alloc_req = 1'b0;
        #1;
        chk("R1 upper bits read zero", reg_rdata, 32'h9);
        chk("R7 no request quiet", {30'b0, victim_valid, no_alloc}, 32'h0);

        // R2: mid-run reset restores mask and pointer
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        alloc_req = 1'b1;
        #1;
        chk("R2 mask after reset", reg_rdata, 32'h0);
        chk("R2 first way after reset", {29'b0, victim_valid, victim_way}, {29'b0, 1'b1, 2'd0});

        // Random phase: R3 R4 R5 R6 R8
        m_mask = '0; m_ptr = 2'd1;
        for (int w = 0; w < 4; w++) seen[w] = 0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            reg_wr    = ($urandom % 6) == 0;
            reg_wdata = $urandom;
            if (($urandom % 3) == 0) reg_wdata[3:0] = 4'hF ^ (4'h1 << ($urandom % 4));
            alloc_req = ($urandom % 4) != 0;
            #1;
            e_v = 1'b0; e_w = m_ptr;
            for (int k = 3; k >= 0; k--) begin
                if (!m_mask[m_ptr + 2'(k)]) begin e_v = 1'b1; e_w = m_ptr + 2'(k); end
            end
            chk("R3/R6 random valid", {31'b0, victim_valid}, {31'b0, alloc_req & e_v});
            chk("R6 random no_alloc", {31'b0, no_alloc}, {31'b0, alloc_req & ~e_v});
            if (alloc_req && e_v) begin
                chk("R3/R4/R5 random way", {30'b0, victim_way}, {30'b0, e_w});
                seen[e_w]++;
                m_ptr = e_w + 2'd1;
            end
            if (reg_wr) m_mask = reg_wdata[3:0];
        end
        for (int w = 0; w < 4; w++)
            chk($sformatf("R4 way %0d chosen at some point", w), {31'b0, seen[w] > 0}, 32'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule